// File: doc/BRIEF.md
# Translation-Fill Barrier Interlock

This controller orders a translation-buffer refill behind a memory barrier so that the refill stays coherent in a multiprocessor system. It accepts one page-table-entry load at a time and tags it as a data-side or an instruction-side fill. It marks the dependent entry-install write in a small scoreboard. It allows that write to issue only once the load has returned its data. When the write issues, the controller hands a barrier request to the cache/bus unit. The scoreboard bit that blocks later memory operations stays set until both the install write has retired and the barrier completion has come back.

On an instruction-side fill, instruction fetch is stalled from the moment the load returns data. The stall lasts until the barrier has been resolved and the probe queue reports empty. A one-cycle restart-prefetch pulse then tells the fetch unit to resume. A global enable removes the barrier step for uniprocessor use. A sequence-select input chooses which of two barrier sequences the cache/bus unit runs. The sequence-select only travels with the request and does not change the interlock.

The controller is a five-state machine:
- `ST_IDLE`: ready for a load.
- `ST_LOAD`: load outstanding.
- `ST_FILL`: data returned, install write may issue.
- `ST_BAR`: waiting for barrier completion.
- `ST_WRET`: waiting for the install write to retire.

Its transitions are:
- start (`ST_IDLE`→`ST_LOAD`, on an accepted load)
- data (`ST_LOAD`→`ST_FILL`)
- issue-with-barrier (`ST_FILL`→`ST_BAR`)
- issue-without-barrier (`ST_FILL`→`ST_WRET`)
- barrier-done-early (`ST_BAR`→`ST_WRET`)
- barrier-done-last (`ST_BAR`→`ST_IDLE`, when the write has already retired)
- retire (`ST_WRET`→`ST_IDLE`)

Top module: `tfb_interlock`

## Requirements
- R1: While `rst` is high, and at the first sample after it is released, `sb_hold` is all zero, `fetch_stall`, `bar_req` and `prefetch_go` are low and `pte_ld_ready` is high.
- R2: Only one fill is in flight. `pte_ld_ready` is low from the cycle after an accepted load until the fill has ended and `fetch_stall` is low. A `pte_ld_start` seen while `pte_ld_ready` is low is ignored.
- R3: The cycle after `wr_queue`, bits 4 and 0 of `sb_hold` (value 0x11) are set.
- R4: `wr_issue_ok` is high only in the cycles after the load has returned data (`pte_ld_data`) and before the install write issues.
- R5: With `bar_en` high, an issue raises `bar_req` for exactly one cycle, the cycle after the issue. `bar_seq` in that cycle equals `bus_seq_sel` as sampled with the issue.
- R6: `sb_hold` bit 4 clears the cycle after `wr_retire`. Bit 0 clears the cycle after the later of `wr_retire` and `bar_done`.
- R7: With `bar_en` low, no `bar_req` is raised, and bit 0 clears the cycle after `wr_retire` alone.
- R8: On an instruction-side fill (`pte_ld_side`=1), `fetch_stall` rises the cycle after `pte_ld_data`. It falls the cycle after `probe_empty` is seen with the barrier already resolved. `prefetch_go` is high for exactly that one cycle.
- R9: A data-side fill (`pte_ld_side`=0) never raises `fetch_stall` or `prefetch_go`.
- R10: A `bar_done` while no barrier is awaited leaves `sb_hold` and the controller state unchanged, and raises `bar_err` for one cycle, the next one.
- R11: The interlock waits for `bar_done` in the same way for both values of `bus_seq_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bar_en | input | 1 | Global barrier-insertion enable |
| pte_ld_start | input | 1 | Page-table-entry load issued |
| pte_ld_side | input | 1 | Fill target: 0 data, 1 instruction |
| pte_ld_ready | output | 1 | A new load is accepted |
| pte_ld_data | input | 1 | Load has returned data |
| wr_queue | input | 1 | Install write queued |
| wr_issue | input | 1 | Install write issues |
| wr_issue_ok | output | 1 | Install write may issue |
| wr_retire | input | 1 | Install write retired |
| bus_seq_sel | input | 1 | Barrier sequence select |
| bar_req | output | 1 | Barrier request pulse |
| bar_seq | output | 1 | Sequence select sent with the request |
| bar_done | input | 1 | Barrier completion pulse |
| bar_err | output | 1 | Completion with no request outstanding |
| probe_empty | input | 1 | Probe queue drained |
| sb_hold | output | SB_W | Scoreboard bits |
| fetch_stall | output | 1 | Instruction fetch held |
| prefetch_go | output | 1 | Restart-prefetch pulse |

## Verification
The hardest situation to reach is the one where the two clearing events for bit 0 arrive in either order. The same situation has to be combined with a probe queue that is still busy after the barrier has resolved. The bench therefore sweeps every combination of the following:
- fill side
- barrier enable
- sequence select
- retire-before-completion versus completion-before-retire
- zero to two cycles of extra probe-queue occupancy

In each case it holds `probe_empty` low until after bit 0 has cleared, so that the stall release is seen separately. Stray completions and a second load offered while busy are injected at fixed points.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FILL,
        ST_BAR,
        ST_WRET
    } fill_st_t;

    localparam logic SIDE_DATA  = 1'b0;
    localparam logic SIDE_INSTR = 1'b1;

endpackage

// File: rtl/tfb_fsm.sv
module tfb_fsm
    import tfb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bar_en,
    input  logic pte_ld_start,
    input  logic pte_ld_side,
    input  logic stall_busy,
    input  logic pte_ld_data,
    input  logic wr_issue,
    input  logic wr_retire,
    input  logic bus_seq_sel,
    input  logic bar_done,
    output logic ld_ready,
    output logic issue_ok,
    output logic fill_start,
    output logic fill_end,
    output logic bar_ok_set,
    output logic instr_ld_end,
    output logic bar_req,
    output logic bar_seq,
    output logic bar_err
);

    fill_st_t st_q, st_d;
    logic     side_q;
    logic     retired_q;
    logic     bar_req_q, bar_seq_q, bar_err_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (pte_ld_start && !stall_busy) st_d = ST_LOAD;
            ST_LOAD: if (pte_ld_data) st_d = ST_FILL;
            ST_FILL: if (wr_issue) st_d = bar_en ? ST_BAR : ST_WRET;
            ST_BAR:  if (bar_done) st_d = (retired_q || wr_retire) ? ST_IDLE : ST_WRET;
            ST_WRET: if (wr_retire) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_ready     = (st_q == ST_IDLE) && !stall_busy;
        issue_ok     = (st_q == ST_FILL);
        fill_start   = ld_ready && pte_ld_start;
        fill_end     = ((st_q == ST_BAR) && bar_done && (retired_q || wr_retire))
                     || ((st_q == ST_WRET) && wr_retire);
        bar_ok_set   = ((st_q == ST_BAR) && bar_done)
                     || ((st_q == ST_FILL) && wr_issue && !bar_en);
        instr_ld_end = (st_q == ST_LOAD) && pte_ld_data && (side_q == SIDE_INSTR);
        bar_req      = bar_req_q;
        bar_seq      = bar_seq_q;
        bar_err      = bar_err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_q    <= SIDE_DATA;
            retired_q <= 1'b0;
            bar_req_q <= 1'b0;
            bar_seq_q <= 1'b0;
            bar_err_q <= 1'b0;
        end else begin
            if (fill_start) side_q <= pte_ld_side;
            if (st_q != ST_BAR)  retired_q <= 1'b0;
            else if (wr_retire)  retired_q <= 1'b1;
            bar_req_q <= (st_q == ST_FILL) && wr_issue && bar_en;
            if ((st_q == ST_FILL) && wr_issue && bar_en) bar_seq_q <= bus_seq_sel;
            bar_err_q <= bar_done && (st_q != ST_BAR);
        end
    end

endmodule

// File: rtl/tfb_scoreboard.sv
module tfb_scoreboard #(
    parameter int SB_W      = 8,
    parameter int BIT_ISSUE = 4,
    parameter int BIT_MEM   = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_queue,
    input  logic            wr_retire,
    input  logic            fill_end,
    output logic [SB_W-1:0] sb_o
);

    for (genvar b = 0; b < SB_W; b++) begin : g_bit
        if (b == BIT_ISSUE) begin : g_issue
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)            bit_q <= 1'b0;
                else if (wr_queue)  bit_q <= 1'b1;
                else if (wr_retire) bit_q <= 1'b0;
            end
            assign sb_o[b] = bit_q;
        end else if (b == BIT_MEM) begin : g_mem
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)           bit_q <= 1'b0;
                else if (wr_queue) bit_q <= 1'b1;
                else if (fill_end) bit_q <= 1'b0;
            end
            assign sb_o[b] = bit_q;
        end else begin : g_idle
            assign sb_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/tfb_fetch_gate.sv
module tfb_fetch_gate (
    input  logic clk,
    input  logic rst,
    input  logic fill_start,
    input  logic instr_ld_end,
    input  logic bar_ok_set,
    input  logic probe_empty,
    output logic fetch_stall,
    output logic prefetch_go
);

    logic stall_q, ok_q, go_q, release_now;

    assign release_now = stall_q && ok_q && probe_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
            ok_q    <= 1'b0;
            go_q    <= 1'b0;
        end else begin
            if (fill_start)      ok_q <= 1'b0;
            else if (bar_ok_set) ok_q <= 1'b1;
            if (instr_ld_end)     stall_q <= 1'b1;
            else if (release_now) stall_q <= 1'b0;
            go_q <= release_now;
        end
    end

    assign fetch_stall = stall_q;
    assign prefetch_go = go_q;

endmodule

// File: rtl/tfb_interlock.sv
module tfb_interlock #(
    parameter int SB_W      = 8,
    parameter int BIT_ISSUE = 4,
    parameter int BIT_MEM   = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bar_en,
    input  logic            pte_ld_start,
    input  logic            pte_ld_side,
    output logic            pte_ld_ready,
    input  logic            pte_ld_data,
    input  logic            wr_queue,
    input  logic            wr_issue,
    output logic            wr_issue_ok,
    input  logic            wr_retire,
    input  logic            bus_seq_sel,
    output logic            bar_req,
    output logic            bar_seq,
    input  logic            bar_done,
    output logic            bar_err,
    input  logic            probe_empty,
    output logic [SB_W-1:0] sb_hold,
    output logic            fetch_stall,
    output logic            prefetch_go
);

    logic fill_start, fill_end, bar_ok_set, instr_ld_end;

    tfb_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .bar_en       (bar_en),
        .pte_ld_start (pte_ld_start),
        .pte_ld_side  (pte_ld_side),
        .stall_busy   (fetch_stall),
        .pte_ld_data  (pte_ld_data),
        .wr_issue     (wr_issue),
        .wr_retire    (wr_retire),
        .bus_seq_sel  (bus_seq_sel),
        .bar_done     (bar_done),
        .ld_ready     (pte_ld_ready),
        .issue_ok     (wr_issue_ok),
        .fill_start   (fill_start),
        .fill_end     (fill_end),
        .bar_ok_set   (bar_ok_set),
        .instr_ld_end (instr_ld_end),
        .bar_req      (bar_req),
        .bar_seq      (bar_seq),
        .bar_err      (bar_err)
    );

    tfb_scoreboard #(
        .SB_W      (SB_W),
        .BIT_ISSUE (BIT_ISSUE),
        .BIT_MEM   (BIT_MEM)
    ) u_sb (
        .clk       (clk),
        .rst       (rst),
        .wr_queue  (wr_queue),
        .wr_retire (wr_retire),
        .fill_end  (fill_end),
        .sb_o      (sb_hold)
    );

    tfb_fetch_gate u_fetch (
        .clk          (clk),
        .rst          (rst),
        .fill_start   (fill_start),
        .instr_ld_end (instr_ld_end),
        .bar_ok_set   (bar_ok_set),
        .probe_empty  (probe_empty),
        .fetch_stall  (fetch_stall),
        .prefetch_go  (prefetch_go)
    );

endmodule

// File: rtl/tfb_interlock_chk.sv
module tfb_interlock_chk #(
    parameter int SB_W      = 8,
    parameter int BIT_ISSUE = 4,
    parameter int BIT_MEM   = 0
) (
    input logic            clk,
    input logic            rst,
    input logic            bar_en,
    input logic            bar_done,
    input logic            bar_req,
    input logic            bar_err,
    input logic [SB_W-1:0] sb_hold,
    input logic            fetch_stall,
    input logic            prefetch_go
);

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bar_req |=> !bar_req); // R5

    AST_ISSUE_BIT_IMPLIES_MEM_BIT: assert property (@(posedge clk) disable iff (rst)
        sb_hold[BIT_ISSUE] |-> sb_hold[BIT_MEM]); // R6

    AST_NO_REQ_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        $past(!bar_en) |-> !bar_req); // R7

    AST_RESTART_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(fetch_stall) |-> prefetch_go); // R8

    AST_ERR_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (rst)
        bar_err |-> $past(bar_done)); // R10

endmodule

bind tfb_interlock tfb_interlock_chk #(
    .SB_W      (SB_W),
    .BIT_ISSUE (BIT_ISSUE),
    .BIT_MEM   (BIT_MEM)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bar_en      (bar_en),
    .bar_done    (bar_done),
    .bar_req     (bar_req),
    .bar_err     (bar_err),
    .sb_hold     (sb_hold),
    .fetch_stall (fetch_stall),
    .prefetch_go (prefetch_go)
);

// File: tb/test_tfb_interlock.sv
module test_tfb_interlock;

    localparam int CLK_PERIOD = 10;
    localparam int SB_W       = 8;
    localparam int BIT_ISSUE  = 4;
    localparam int BIT_MEM    = 0;
    localparam logic [SB_W-1:0] SB_BOTH = (SB_W'(1) << BIT_ISSUE) | (SB_W'(1) << BIT_MEM);
    localparam logic [SB_W-1:0] SB_MEM  = SB_W'(1) << BIT_MEM;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bar_en = 1'b0, pte_ld_start = 1'b0, pte_ld_side = 1'b0, pte_ld_data = 1'b0;
    logic wr_queue = 1'b0, wr_issue = 1'b0, wr_retire = 1'b0, bus_seq_sel = 1'b0;
    logic bar_done = 1'b0, probe_empty = 1'b0;
    logic pte_ld_ready, wr_issue_ok, bar_req, bar_seq, bar_err, fetch_stall, prefetch_go;
    logic [SB_W-1:0] sb_hold;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tfb_interlock #(.SB_W(SB_W), .BIT_ISSUE(BIT_ISSUE), .BIT_MEM(BIT_MEM)) i_tfb_interlock (
        .clk(clk), .rst(rst), .bar_en(bar_en), .pte_ld_start(pte_ld_start),
        .pte_ld_side(pte_ld_side), .pte_ld_ready(pte_ld_ready), .pte_ld_data(pte_ld_data),
        .wr_queue(wr_queue), .wr_issue(wr_issue), .wr_issue_ok(wr_issue_ok),
        .wr_retire(wr_retire), .bus_seq_sel(bus_seq_sel), .bar_req(bar_req),
        .bar_seq(bar_seq), .bar_done(bar_done), .bar_err(bar_err),
        .probe_empty(probe_empty), .sb_hold(sb_hold), .fetch_stall(fetch_stall),
        .prefetch_go(prefetch_go)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic run_fill(input logic side, input logic en, input logic seq,
                            input logic ret_first, input int pdelay);
        bar_en = en;
        chk("R2 ready before fill", 32'(pte_ld_ready), 1);
        pte_ld_start = 1'b1; pte_ld_side = side;
        tick;
        chk("R2 busy after accept", 32'(pte_ld_ready), 0);
        chk("R4 no issue before data", 32'(wr_issue_ok), 0);
        wr_queue = 1'b1;                      // pte_ld_start still high: R2 ignored
        pte_ld_side = ~side;
        tick;
        pte_ld_start = 1'b0; wr_queue = 1'b0;
        chk("R3 bits 4 and 0 set", 32'(sb_hold), 32'(SB_BOTH));
        chk("R4 still no issue", 32'(wr_issue_ok), 0);
        pte_ld_data = 1'b1;
        tick;
        pte_ld_data = 1'b0;
        chk("R4 issue allowed", 32'(wr_issue_ok), 1);
        chk("R8 R9 stall at data end", 32'(fetch_stall), 32'(side));
        wr_issue = 1'b1; bus_seq_sel = seq;
        tick;
        wr_issue = 1'b0; bus_seq_sel = ~seq;
        chk("R4 issue closed", 32'(wr_issue_ok), 0);
        chk("R5 R7 request", 32'(bar_req), 32'(en));
        if (en) chk("R5 R11 sequence", 32'(bar_seq), 32'(seq));
        if (!en) begin
            wr_retire = 1'b1;
            tick;
            wr_retire = 1'b0;
            chk("R7 no request", 32'(bar_req), 0);
            chk("R7 bits clear on retire", 32'(sb_hold), 0);
        end else if (ret_first) begin
            wr_retire = 1'b1;
            tick;
            wr_retire = 1'b0;
            chk("R5 pulse ended", 32'(bar_req), 0);
            chk("R6 bit4 cleared bit0 held", 32'(sb_hold), 32'(SB_MEM));
            tick; tick;
            chk("R6 R11 bit0 waits completion", 32'(sb_hold), 32'(SB_MEM));
            bar_done = 1'b1;
            tick;
            bar_done = 1'b0;
            chk("R6 bit0 clears on completion", 32'(sb_hold), 0);
            chk("R10 valid completion no error", 32'(bar_err), 0);
        end else begin
            tick;
            chk("R5 pulse ended", 32'(bar_req), 0);
            tick;
            bar_done = 1'b1;
            tick;
            bar_done = 1'b0;
            chk("R6 bits held until retire", 32'(sb_hold), 32'(SB_BOTH));
            chk("R10 valid completion no error", 32'(bar_err), 0);
            wr_retire = 1'b1;
            tick;
            wr_retire = 1'b0;
            chk("R6 bits clear on retire", 32'(sb_hold), 0);
        end
        if (side) begin
            chk("R8 stall while probes pending", 32'(fetch_stall), 1);
            chk("R2 busy while stalled", 32'(pte_ld_ready), 0);
            for (int d = 0; d < pdelay; d++) begin
                tick;
                chk("R8 stall held", 32'(fetch_stall), 1);
            end
            probe_empty = 1'b1;
            tick;
            probe_empty = 1'b0;
            chk("R8 stall released", 32'(fetch_stall), 0);
            chk("R8 prefetch restart", 32'(prefetch_go), 1);
            tick;
            chk("R8 restart single cycle", 32'(prefetch_go), 0);
        end else begin
            probe_empty = 1'b1;
            tick;
            probe_empty = 1'b0;
            chk("R9 no stall on data side", 32'(fetch_stall), 0);
            chk("R9 no restart on data side", 32'(prefetch_go), 0);
        end
        chk("R2 ready after fill", 32'(pte_ld_ready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run;
    end

    initial begin
        tick; tick;
        chk("R1 reset sb", 32'(sb_hold), 0);
        chk("R1 reset stall", 32'(fetch_stall), 0);
        tick;
        rst = 1'b0;
        tick;
        chk("R1 sb after reset", 32'(sb_hold), 0);
        chk("R1 ready after reset", 32'(pte_ld_ready), 1);
        chk("R1 no request", 32'(bar_req), 0);
        chk("R1 no restart", 32'(prefetch_go), 0);

        bar_done = 1'b1;                      // stray completion while idle
        tick;
        bar_done = 1'b0;
        chk("R10 error flagged", 32'(bar_err), 1);
        chk("R10 sb untouched", 32'(sb_hold), 0);
        chk("R10 still idle", 32'(pte_ld_ready), 1);
        tick;
        chk("R10 error single cycle", 32'(bar_err), 0);

        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 2; e++)
                for (int q = 0; q < 2; q++)
                    for (int o = 0; o < 2; o++)
                        for (int p = 0; p < 3; p++)
                            run_fill(s[0], e[0], q[0], o[0], p);

        bar_en = 1'b1;                        // stray completion mid-fill
        pte_ld_start = 1'b1; pte_ld_side = 1'b0;
        tick;
        pte_ld_start = 1'b0; wr_queue = 1'b1;
        tick;
        wr_queue = 1'b0; pte_ld_data = 1'b1;
        tick;
        pte_ld_data = 1'b0; bar_done = 1'b1;
        tick;
        bar_done = 1'b0;
        chk("R10 error during fill", 32'(bar_err), 1);
        chk("R10 fill state kept", 32'(wr_issue_ok), 1);
        chk("R10 sb kept", 32'(sb_hold), 32'(SB_BOTH));
        wr_issue = 1'b1;
        tick;
        wr_issue = 1'b0; wr_retire = 1'b1;
        tick;
        wr_retire = 1'b0; bar_done = 1'b1;
        tick;
        bar_done = 1'b0;
        chk("R6 closes after stray", 32'(sb_hold), 0);
        finish_run;
    end

endmodule